// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a digital undervoltage indication, a manual reset request and a software watchdog kick into one clean system reset. An external comparator supplies `uv_raw`, which goes high while the monitored supply is below its threshold. The block filters out short dips on that input. It holds reset asserted while the supply is low, then stretches the reset for a fixed timeout once the supply recovers. It drives an active-high and an active-low copy of the reset, plus a flag that tells the memory controller to abort transfers and refuse new ones.

The active-low reset is shared with a push-button, so the board line is the wired AND of the button and this block's own drive. The block watches that line through `mrst_sense_n`. A falling edge that the block did not cause starts a full timeout. A watchdog counts idle cycles between edges on `wd_kick` and forces a reset when it runs out. Every duration is a parameter counted in clock cycles. `rst_n` is the power-on reset for the logic itself.

Top module: `sup_reset_seq`

## Requirements
- R1: While `rst_n` is low, `rst_out`=1, `rst_n_out`=0 and `mem_disable`=1. After `rst_n` rises, these hold for another TIMEOUT_CYC clock edges before release.
- R2: Once `uv_raw` passes the filter, reset is asserted on the next edge and held while the filtered indication stays high. It is released exactly TIMEOUT_CYC edges after the filtered indication clears, which happens on the first edge that samples `uv_raw` low.
- R3: `uv_raw` (high = undervoltage) counts only after GLITCH_CYC consecutive high samples. The filter output rises on the edge of the GLITCH_CYC-th sample. A pulse of GLITCH_CYC-1 samples leaves every output unchanged.
- R4: A falling edge on `mrst_sense_n` seen while reset is deasserted starts a full timeout. The input passes two synchronising flip-flops, so if edge a is the first to sample the low level, reset asserts on edge a+2. It is then held for TIMEOUT_CYC edges whatever the pulse length. A low level held past the timeout, or a rising edge, has no further effect.
- R5: Falling edges on `mrst_sense_n` that arrive while reset is asserted, including the one caused by the block's own drive, do not restart the timeout.
- R6: If WDOG_CYC edges pass after a reset release with no kick edge, the watchdog expires and reset asserts on edge r+WDOG_CYC+1, where r is the release edge.
- R7: A rising or a falling edge on `wd_kick` (synchronised by two flip-flops) clears the watchdog count. A change applied before edge k clears it on edge k+2.
- R8: While reset is asserted, the watchdog count does not advance and stays cleared, however long the reset lasts.
- R9: A watchdog expiry produces one full TIMEOUT_CYC reset. After that the watchdog counts again from zero.
- R10: On every cycle `rst_n_out` is the complement of `rst_out`, and `mem_disable` equals `rst_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| uv_raw | input | 1 | Comparator output, high while the supply is below threshold |
| mrst_sense_n | input | 1 | Sensed level of the shared active-low reset line |
| wd_kick | input | 1 | Watchdog kick; any edge counts as activity |
| rst_out | output | 1 | System reset, active high |
| rst_n_out | output | 1 | System reset, active low; drives the shared line |
| mem_disable | output | 1 | Memory access block, high while reset is active |

## Verification
The undervoltage input is tried with three pulses: one sample short of the filter length, exactly the filter length, and a long dip. These separate an off-by-one in the filter from a correct filter, and show the release counted from the recovery edge. The watchdog is left idle, kicked once with a rising edge and once with a falling edge, and left idle across a long undervoltage reset. The expiry cycle then shows whether either edge clears the count, and whether the count was frozen during reset. Short and long manual pulses separate edge triggering from level sensing. Every release cycle after a reset the block asserted itself would move by three if the block's own drive on the shared line were mistaken for a button press.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Which edge of a synchronised input produces the output pulse.
    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_ANY  = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/sup_sync_edge.sv
module sup_sync_edge
    import sup_pkg::*;
#(
    parameter int        STAGES  = 2,
    parameter logic      RST_VAL = 1'b0,
    parameter edge_sel_e MODE    = EDGE_FALL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     level;

    always_comb begin
        level       = st_q.chain[STAGES-1];
        st_d.chain  = {st_q.chain[STAGES-2:0], async_in};
        st_d.prev   = level;
    end

    generate
        if (MODE == EDGE_ANY) begin : g_any
            assign pulse = level ^ st_q.prev;
        end else begin : g_fall
            assign pulse = ~level & st_q.prev;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RST_VAL}};
            st_q.prev  <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sup_glitch_filter.sv
module sup_glitch_filter #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic filt_out
);

    localparam int            GW     = $clog2(GLITCH_CYC + 1);
    localparam logic [GW-1:0] G_LAST = GW'(GLITCH_CYC - 1);

    typedef struct packed {
        logic [GW-1:0] cnt;
        logic          filt;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!raw_in) begin
            st_d.cnt  = '0;
            st_d.filt = 1'b0;
        end else begin
            st_d.filt = (st_q.cnt == G_LAST);
            if (st_q.cnt != G_LAST) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_out = st_q.filt;

    // R3
    filt_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.filt |-> $past(raw_in));

    // R3
    filt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.filt) |-> $past(st_q.cnt) == G_LAST);

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
    parameter int WDOG_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic hold,
    output logic expire
);

    localparam int            WW     = $clog2(WDOG_CYC + 1);
    localparam logic [WW-1:0] W_LAST = WW'(WDOG_CYC - 1);

    typedef struct packed {
        logic [WW-1:0] cnt;
        logic          expire;
    } wd_st_t;

    wd_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.expire = 1'b0;
        if (hold || kick) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == W_LAST) begin
            st_d.cnt    = '0;
            st_d.expire = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire = st_q.expire;

    // R8
    wd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st_q.cnt == '0) && !st_q.expire);

    // R7
    wd_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (st_q.cnt == '0) && !st_q.expire);

    // R6
    wd_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.expire |-> $past(st_q.cnt) == W_LAST && !$past(hold));

endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
    import sup_pkg::*;
#(
    parameter int GLITCH_CYC  = 4,
    parameter int TIMEOUT_CYC = 20_000_000,
    parameter int WDOG_CYC    = 160_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_raw,
    input  logic mrst_sense_n,
    input  logic wd_kick,
    output logic rst_out,
    output logic rst_n_out,
    output logic mem_disable
);

    localparam int            TW     = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic          active;
        logic [TW-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    uv_filt;
    logic    mr_fall;
    logic    kick_edge;
    logic    wd_exp;
    logic    trigger;

    sup_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) i_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (uv_raw),
        .filt_out (uv_filt)
    );

    sup_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .MODE(EDGE_FALL)) i_mr_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mrst_sense_n),
        .pulse    (mr_fall)
    );

    sup_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .MODE(EDGE_ANY)) i_kick_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wd_kick),
        .pulse    (kick_edge)
    );

    sup_watchdog #(.WDOG_CYC(WDOG_CYC)) i_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (kick_edge),
        .hold   (st_q.active),
        .expire (wd_exp)
    );

    // Manual edges count only while the block is not itself driving the line.
    assign trigger = uv_filt | wd_exp | (mr_fall & ~st_q.active);

    always_comb begin
        st_d = st_q;
        if (trigger) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == T_LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_out     = st_q.active;
    assign rst_n_out   = ~st_q.active;
    assign mem_disable = st_q.active;

    // R2
    uv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_filt |=> st_q.active && st_q.cnt == '0);

    // R2
    release_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.active) |-> $past(st_q.cnt) == T_LAST && !$past(uv_filt));

    // R4
    manual_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_fall && !st_q.active) |=> st_q.active && st_q.cnt == '0);

    // R5
    own_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_fall && st_q.active && !uv_filt && !wd_exp && st_q.cnt != T_LAST)
            |=> st_q.cnt == $past(st_q.cnt) + 1'b1);

    // R6
    wd_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_exp |=> st_q.active && st_q.cnt == '0);

endmodule

// File: tb/test_sup_reset_seq.sv
module test_sup_reset_seq;

    localparam int G  = 4;
    localparam int T  = 20;
    localparam int WD = 40;

    logic clk     = 1'b0;
    logic rst_n   = 1'b0;
    logic uv_raw  = 1'b0;
    logic ext_n   = 1'b1;
    logic wd_kick = 1'b0;
    logic rst_out, rst_n_out, mem_disable;
    logic mrst_line;

    // Shared line: wired AND of the push-button and the block's own drive.
    assign mrst_line = ext_n & rst_n_out;

    sup_reset_seq #(
        .GLITCH_CYC  (G),
        .TIMEOUT_CYC (T),
        .WDOG_CYC    (WD),
        .SYNC_STAGES (2)
    ) i_sup_reset_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv_raw       (uv_raw),
        .mrst_sense_n (mrst_line),
        .wd_kick      (wd_kick),
        .rst_out      (rst_out),
        .rst_n_out    (rst_n_out),
        .mem_disable  (mem_disable)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    val;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_chk  = 0;
    int   n_fail = 0;

    task automatic expect_at(int at, bit val, string tag);
        q.push_back('{at, val, tag});
    endtask

    task automatic wait_cyc(int n);
        do @(negedge clk); while (cyc < n);
    endtask

    // Monitor: pops items whose cycle has come and compares (R10 on every item).
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            cur = q.pop_front();
            n_chk++;
            if (cur.at != cyc || rst_out !== cur.val || rst_n_out !== !cur.val ||
                mem_disable !== cur.val) begin
                n_fail++;
                $display("FAIL %s / R10 at cycle %0d (due %0d): rst_out=%b rst_n_out=%b mem_disable=%b expected rst_out=%b rst_n_out=%b mem_disable=%b",
                         cur.tag, cyc, cur.at, rst_out, rst_n_out, mem_disable,
                         cur.val, !cur.val, cur.val);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        // Expected items, in cycle order.
        expect_at(1,   1, "R1 reset state");
        expect_at(22,  1, "R1 power-on timeout");
        expect_at(23,  0, "R1 power-on release");
        expect_at(63,  0, "R6 before watchdog expiry");
        expect_at(64,  1, "R6 watchdog expiry");
        expect_at(83,  1, "R9 expiry timeout");
        expect_at(84,  0, "R5 own drive ignored / R9 release");
        expect_at(125, 0, "R7 rising kick cleared count");
        expect_at(143, 0, "R7 before expiry after rising kick");
        expect_at(144, 1, "R7 expiry after rising kick");
        expect_at(163, 1, "R9 timeout");
        expect_at(164, 0, "R9 release");
        expect_at(205, 0, "R7 falling kick cleared count");
        expect_at(223, 0, "R7 before expiry after falling kick");
        expect_at(224, 1, "R7 expiry after falling kick");
        expect_at(243, 1, "R9 timeout");
        expect_at(244, 0, "R9 release");
        expect_at(255, 0, "R3 short pulse ignored");
        expect_at(258, 0, "R3 short pulse ignored");
        expect_at(264, 0, "R3 filter length");
        expect_at(265, 1, "R3 exact pulse accepted");
        expect_at(284, 1, "R2 timeout after dip");
        expect_at(285, 0, "R2 release / R5 own drive ignored");
        expect_at(294, 0, "R2 before long dip");
        expect_at(295, 1, "R2 long dip asserted");
        expect_at(330, 1, "R2 held during dip");
        expect_at(370, 1, "R2 timeout after recovery");
        expect_at(371, 0, "R2 release after recovery");
        expect_at(411, 0, "R8 watchdog frozen during reset");
        expect_at(412, 1, "R8 expiry counted from release");
        expect_at(431, 1, "R9 timeout");
        expect_at(432, 0, "R9 release");
        expect_at(472, 0, "R9 count resumed");
        expect_at(473, 1, "R9 second expiry");
        expect_at(492, 1, "R9 timeout");
        expect_at(493, 0, "R9 release");
        expect_at(502, 0, "R4 manual sync delay");
        expect_at(503, 1, "R4 manual asserted");
        expect_at(522, 1, "R4 short press stretched");
        expect_at(523, 0, "R4 release");
        expect_at(542, 0, "R4 long press sync delay");
        expect_at(543, 1, "R4 long press asserted");
        expect_at(562, 1, "R4 timeout");
        expect_at(563, 0, "R4 release while still held");
        expect_at(580, 0, "R4 low level ignored");
        expect_at(595, 0, "R4 rising edge ignored");
        expect_at(603, 0, "R9 count from release");
        expect_at(604, 1, "R9 expiry after manual reset");

        wait_cyc(3);   rst_n   = 1'b1;
        wait_cyc(100); wd_kick = 1'b1;
        wait_cyc(180); wd_kick = 1'b0;
        wait_cyc(250); uv_raw  = 1'b1;
        wait_cyc(253); uv_raw  = 1'b0;
        wait_cyc(260); uv_raw  = 1'b1;
        wait_cyc(264); uv_raw  = 1'b0;
        wait_cyc(290); uv_raw  = 1'b1;
        wait_cyc(350); uv_raw  = 1'b0;
        wait_cyc(500); ext_n   = 1'b0;
        wait_cyc(503); ext_n   = 1'b1;
        wait_cyc(540); ext_n   = 1'b0;
        wait_cyc(590); ext_n   = 1'b1;
        wait_cyc(610);
        if (q.size() != 0) begin
            n_fail += q.size();
            $display("FAIL %s: %0d items never compared, expected 0", q[0].tag, q.size());
        end
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung at cycle %0d, expected end by 610", cyc);
        finish_run();
    end

endmodule